// File: doc/BRIEF.md
# Binary GCD Engine

This block finds the greatest common divisor of two 32-bit unsigned numbers without any divider. It uses the binary method. First it removes the power of two that both operands share and remembers how many halvings that took. It then makes the first operand odd. After that it repeats one step until the second operand reaches zero: make the second operand odd, keep the smaller of the two values, and halve their difference. The saved power of two is restored on the way out.

A client drives the operands and pulses `start_i` for one cycle. The engine works through its steps at one operation per clock and then raises `done_o` for a single cycle. The answer on `result_o` is held until the next completion. Only one operation runs at a time. A start request that arrives while a computation is in flight is dropped.

Top module: `gcd_engine`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after its release, `done_o` is 0 and `result_o` is 0.
- R2: If either operand sampled with `start_i` is zero, the result is the bitwise OR of the two operands, so gcd(0,0)=0 and gcd(0,x)=x.
- R3: The power of two that divides both operands is kept in the result. For example, gcd(96,64)=32 and gcd(0x80000000,0x40000000)=0x40000000.
- R4: For two nonzero operands the result equals their greatest common divisor. This covers equal operands, coprime operands, an operand of 1 and operands near 0xFFFFFFFF.
- R5: Latency. Take the rising edge that samples `start_i` in the idle state as edge 0. `done_o` is high right after edge L. With a zero operand, L = 1. Otherwise L = s + a + B + 2k + 3, where s is the number of common halvings, a is the number of further halvings of u, k is the number of subtract steps, and B is the total number of halvings of v before those steps.
- R6: `done_o` is high for exactly one cycle per accepted start.
- R7: `start_i` is ignored while a computation is in flight. It changes neither the result nor the completion cycle of the current operation.
- R8: `result_o` changes only in the cycle in which `done_o` rises, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request, sampled only when idle |
| u_i | input | 32 | First operand |
| v_i | input | 32 | Second operand |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Greatest common divisor, held between completions |

## Verification
The engine is driven with several groups of operand pairs:
- Zero operands in each position, including gcd(0,0). These separate the early-exit path from the iterative path.
- Pairs that share large powers of two, including the top bit. These show whether the shift count is saved and restored.
- Equal, coprime and near-maximum pairs, plus pseudo-random pairs. These stress the subtract loop and its termination.

A behavioural model works out the result and the exact completion cycle for each pair. The `done_o` and `result_o` ports are compared against this model on every clock. One run also injects a zero-operand start request in the middle of the computation. A correct engine keeps its result and its timing for that run. An engine that accepts the request instead finishes early or returns the wrong value.

// File: rtl/gcd_engine_pkg.sv
package gcd_engine_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_COMMON = 3'd1,
    ST_ODD_U  = 3'd2,
    ST_ODD_V  = 3'd3,
    ST_STEP   = 3'd4,
    ST_FINISH = 3'd5
  } gcd_state_e;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_HALVE = 3'd2,
    OP_HALVE_U = 3'd3,
    OP_HALVE_V = 3'd4,
    OP_STEP  = 3'd5
  } gcd_op_e;

endpackage

// File: rtl/gcd_engine_fsm.sv
module gcd_engine_fsm
  import gcd_engine_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] u_i,
  input  logic [W-1:0] v_i,
  input  logic         u_odd_i,
  input  logic         v_odd_i,
  input  logic         ops_equal_i,
  output gcd_op_e      op_o,
  output logic         finish_o
);

  gcd_state_e state_q, state_d;
  logic       any_zero;

  assign any_zero = (u_i == '0) || (v_i == '0);

  always_comb begin
    state_d  = state_q;
    op_o     = OP_HOLD;
    finish_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          op_o    = OP_LOAD;
          state_d = any_zero ? ST_FINISH : ST_COMMON;
        end
      end
      ST_COMMON: begin
        if (!u_odd_i && !v_odd_i) op_o = OP_HALVE;
        else                      state_d = ST_ODD_U;
      end
      ST_ODD_U: begin
        if (!u_odd_i) op_o = OP_HALVE_U;
        else          state_d = ST_ODD_V;
      end
      ST_ODD_V: begin
        if (!v_odd_i) op_o = OP_HALVE_V;
        else          state_d = ST_STEP;
      end
      ST_STEP: begin
        op_o    = OP_STEP;
        state_d = ops_equal_i ? ST_FINISH : ST_ODD_V;
      end
      ST_FINISH: begin
        finish_o = 1'b1;
        state_d  = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R4: both operands odd whenever a subtract step runs
  a_r4_odd_before_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STEP) |-> (u_odd_i && v_odd_i));

  // R2: zero operand skips straight to completion
  a_r2_zero_shortcut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && any_zero) |=> (state_q == ST_FINISH));

  // R7: a busy engine only returns to idle through finish
  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && state_q != ST_FINISH) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/gcd_engine_dp.sv
module gcd_engine_dp
  import gcd_engine_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  gcd_op_e      op_i,
  input  logic [W-1:0] u_i,
  input  logic [W-1:0] v_i,
  output logic         u_odd_o,
  output logic         v_odd_o,
  output logic         ops_equal_o,
  output logic [W-1:0] combined_o,
  output logic [$clog2(W)-1:0] shift_o
);

  localparam int unsigned SW = $clog2(W);

  logic [W-1:0]  u_q, v_q;
  logic [SW-1:0] sh_q;
  logic          u_le_v;
  logic [W-1:0]  lo, hi;

  assign u_le_v      = (u_q <= v_q);
  assign lo          = u_le_v ? u_q : v_q;
  assign hi          = u_le_v ? v_q : u_q;
  assign u_odd_o     = u_q[0];
  assign v_odd_o     = v_q[0];
  assign ops_equal_o = (u_q == v_q);
  // v is zero after the loop, so this is u; with a zero operand it is u|v
  assign combined_o  = u_q | v_q;
  assign shift_o     = sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      u_q  <= '0;
      v_q  <= '0;
      sh_q <= '0;
    end else begin
      unique case (op_i)
        OP_LOAD: begin
          u_q  <= u_i;
          v_q  <= v_i;
          sh_q <= '0;
        end
        OP_HALVE: begin
          u_q  <= u_q >> 1;
          v_q  <= v_q >> 1;
          sh_q <= sh_q + 1'b1;
        end
        OP_HALVE_U: u_q <= u_q >> 1;
        OP_HALVE_V: v_q <= v_q >> 1;
        OP_STEP: begin
          u_q <= lo;
          v_q <= (hi - lo) >> 1;
        end
        default: ;
      endcase
    end
  end

  // R3: common shift count never wraps
  a_r3_shift_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HALVE) |-> (sh_q != {SW{1'b1}}));

  // R4: the kept operand never grows during a step
  a_r4_min_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_STEP) |=> (u_q <= $past(u_q)));

endmodule

// File: rtl/gcd_engine_out.sv
module gcd_engine_out #(
  parameter int unsigned W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 finish_i,
  input  logic [W-1:0]         odd_part_i,
  input  logic [$clog2(W)-1:0] shift_i,
  output logic                 done_o,
  output logic [W-1:0]         result_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= finish_i;
      if (finish_i) result_o <= odd_part_i << shift_i;
    end
  end

  a_r6_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r8_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
  import gcd_engine_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] u_i,
  input  logic [W-1:0] v_i,
  output logic         done_o,
  output logic [W-1:0] result_o
);

  localparam int unsigned SW = $clog2(W);

  gcd_op_e       op;
  logic          finish, u_odd, v_odd, ops_equal;
  logic [W-1:0]  combined;
  logic [SW-1:0] shift;

  gcd_engine_fsm #(.W(W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .u_i         (u_i),
    .v_i         (v_i),
    .u_odd_i     (u_odd),
    .v_odd_i     (v_odd),
    .ops_equal_i (ops_equal),
    .op_o        (op),
    .finish_o    (finish)
  );

  gcd_engine_dp #(.W(W)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .op_i        (op),
    .u_i         (u_i),
    .v_i         (v_i),
    .u_odd_o     (u_odd),
    .v_odd_o     (v_odd),
    .ops_equal_o (ops_equal),
    .combined_o  (combined),
    .shift_o     (shift)
  );

  gcd_engine_out #(.W(W)) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .finish_i   (finish),
    .odd_part_i (combined),
    .shift_i    (shift),
    .done_o     (done_o),
    .result_o   (result_o)
  );

endmodule

// File: tb/gcd_engine_test.sv
module gcd_engine_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] u_i = '0;
  logic [31:0] v_i = '0;
  logic        done_o;
  logic [31:0] result_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2 clk_i = ~clk_i;  // 250 MHz

  gcd_engine uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .u_i(u_i), .v_i(v_i), .done_o(done_o), .result_o(result_o)
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_gcd(input logic [31:0] a, input logic [31:0] b);
    logic [31:0] t;
    while (b != 0) begin
      t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  // Latency per R5, counted from the algorithm steps.
  function automatic int ref_lat(input logic [31:0] a, input logic [31:0] b);
    int s = 0, ua = 0, bv = 0, k = 0;
    logic [31:0] d;
    if (a == 0 || b == 0) return 1;
    while (!a[0] && !b[0]) begin a >>= 1; b >>= 1; s++; end
    while (!a[0]) begin a >>= 1; ua++; end
    do begin
      while (!b[0]) begin b >>= 1; bv++; end
      if (a <= b) d = b - a;
      else begin d = a - b; a = b; end
      b = d >> 1;
      k++;
    end while (b != 0);
    return s + ua + bv + 2 * k + 3;
  endfunction

  task automatic run_op(input logic [31:0] a, input logic [31:0] b,
                        input bit inject, input string req);
    logic [31:0] er;
    int el;
    er = ref_gcd(a, b);
    el = ref_lat(a, b);
    @(negedge clk_i);
    start_i = 1'b1; u_i = a; v_i = b;
    @(negedge clk_i);
    start_i = 1'b0;
    // cycle-by-cycle comparison; idx = edges after the start edge
    for (int idx = 0; idx <= el + 1; idx++) begin
      if (inject && idx == 1) begin
        start_i = 1'b1; u_i = 32'd0; v_i = 32'd0;
      end else if (inject && idx == 2) begin
        start_i = 1'b0; u_i = a; v_i = b;
      end
      if (idx == el) begin
        chk(done_o === 1'b1, "R5", "done at expected cycle", {31'b0, done_o}, 32'd1);
        chk(result_o === er, req, "result", result_o, er);
      end else begin
        chk(done_o === 1'b0, "R6", "done outside its cycle", {31'b0, done_o}, 32'd0);
      end
      @(negedge clk_i);
    end
    repeat (3) @(negedge clk_i);
    chk(result_o === er, "R8", "result held", result_o, er);
    chk(done_o === 1'b0, "R6", "done idle", {31'b0, done_o}, 32'd0);
  endtask

  initial begin
    logic [31:0] lfsr = 32'hACE1_2357;
    logic [31:0] ra, rb;
    repeat (3) @(negedge clk_i);
    chk(done_o === 1'b0, "R1", "done in reset", {31'b0, done_o}, 32'd0);
    chk(result_o === 32'd0, "R1", "result in reset", result_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(done_o === 1'b0, "R1", "done after reset", {31'b0, done_o}, 32'd0);
    chk(result_o === 32'd0, "R1", "result after reset", result_o, 32'd0);

    run_op(32'd0, 32'd0, 1'b0, "R2");
    run_op(32'd0, 32'd48, 1'b0, "R2");
    run_op(32'd36, 32'd0, 1'b0, "R2");
    run_op(32'd96, 32'd64, 1'b0, "R3");
    run_op(32'h8000_0000, 32'h4000_0000, 1'b0, "R3");
    run_op(32'd48, 32'd18, 1'b0, "R3");
    run_op(32'd17, 32'd17, 1'b0, "R4");
    run_op(32'd13, 32'd7, 1'b0, "R4");
    run_op(32'd1, 32'hFFFF_FFFF, 1'b0, "R4");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b0, "R4");
    run_op(32'd1071, 32'd462, 1'b0, "R4");
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 1'b0, "R4");
    // R7: zero-operand start injected mid-run must be dropped
    run_op(32'd1071, 32'd462, 1'b1, "R7");
    run_op(32'h0003_0000, 32'h0000_0C00, 1'b1, "R7");
    for (int i = 0; i < 20; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr * 32'd6;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr * 32'd10;
      run_op(ra, rb, 1'b0, "R4");
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule